// File: doc/BRIEF.md
# Operand addressing-mode sequencer

This block resolves one instruction operand per request. A 3-bit mode and a 3-bit register selector are presented with a start strobe. The sequencer then computes the effective address and walks any chain of indirect word reads. It also applies the register side effects the mode calls for: post-increment, pre-decrement, or advancing the program counter (register 7) past an index word. When it finishes, it returns the operand value, the final effective address, and a flag that marks a register-direct operand, so that a later stage can write the result back.

The sequencer has a combinational read port into an external eight-entry register file and a single-cycle write port into the same file. Memory is reached through one word-read port with a request/acknowledge handshake. Source and destination operands are handled by two requests in a row. Every register update belonging to an operand is written before that operand's done strobe. The next operand therefore always sees the updated register, and two post-increments of the same register advance it twice.

The control flow is as follows. An idle state accepts a request, and a decode state reads the register and commits the side effect. Zero to four memory states follow: index fetch, index add, pointer read and operand read. A one-cycle done state hands the result on.

Top module: `opnd_seq`

## Requirements
- R1: After reset, done_o, busy_o, mem_req_o and rf_we_o are all low.
- R2: Mode 0 returns the selected register's contents with reg_direct_o=1 and ea_o equal to the register number. It makes no memory read and no register write, and done_o rises two clock edges after the edge that samples start_i.
- R3: Mode 1 performs one read at the register's value. It returns that word with ea_o equal to the register value and leaves the register unchanged.
- R4: Mode 2 reads at the register's value, returns that word with that address as ea_o, and leaves the register 2 higher.
- R5: Mode 3 reads a pointer at the register's value, then reads the operand at the pointer. ea_o is the pointer and the register ends 2 higher.
- R6: Modes 4 and 5 first lower the register by 2 and use the lowered value as the address. Mode 4 reads the operand there. Mode 5 reads a pointer there and then the operand through it, with ea_o equal to the pointer.
- R7: Mode 6 reads an offset word at the PC (register 7) and advances the PC by 2. The effective address is the offset plus the selected register, read after the PC advance, wrapping modulo 2^16. Exactly two memory reads occur.
- R8: Mode 7 behaves as mode 6 and then reads one more pointer. The operand is read at that pointer, for three reads in total, and ea_o is the pointer.
- R9: A memory request holds mem_req_o and mem_addr_o steady until mem_ack_i. Read data is taken only in the acknowledged cycle.
- R10: done_o is a one-cycle pulse. start_i is ignored while busy_o is high. A register update made by one operand is visible to the next operand, so two mode-3 operands on the same register advance it by 4.
- R11: The register file is written in at most one cycle per operand, and the write occurs before done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin resolving an operand (sampled while idle) |
| mode_i | input | 3 | Addressing mode 0..7 |
| reg_i | input | 3 | Register selector, 7 is the PC |
| busy_o | output | 1 | Sequencer is not idle |
| rf_raddr_o | output | 3 | Register-file read select |
| rf_rdata_i | input | 16 | Register-file read data (combinational) |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 3 | Register-file write select |
| rf_wdata_o | output | 16 | Register-file write data |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory byte address (word aligned) |
| mem_ack_i | input | 1 | Memory acknowledge, data valid |
| mem_rdata_i | input | 16 | Memory read data |
| done_o | output | 1 | One-cycle result strobe |
| value_o | output | 16 | Operand value |
| ea_o | output | 16 | Effective address, or register number in mode 0 |
| reg_direct_o | output | 1 | Operand is a register, not memory |

## Verification
Some properties are checked by assertions on every cycle. A pending request must hold its address until acknowledged. The address used after an auto-step must be consistent with the value written back. A register-direct result must never follow a memory request. The captured mode must stay stable while busy, done must be a single pulse, and register writes must not repeat. The bench scenarios cover what needs a memory image to show. These are the values and effective addresses for all eight modes, and the PC-relative index on register 7. They also include 16-bit wrap of the index sum, the number of reads each mode issues, the double advance of a shared register across two operands, and a start that is ignored under slow acknowledges.

// File: rtl/opnd_pkg.sv
package opnd_pkg;
  localparam int MW = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEC,
    ST_IDX,
    ST_ADD,
    ST_PTR,
    ST_RD,
    ST_DONE
  } opnd_state_e;

  localparam logic [MW-1:0] M_REG     = 3'd0;
  localparam logic [MW-1:0] M_DEF     = 3'd1;
  localparam logic [MW-1:0] M_INC     = 3'd2;
  localparam logic [MW-1:0] M_INC_DEF = 3'd3;
  localparam logic [MW-1:0] M_DEC     = 3'd4;
  localparam logic [MW-1:0] M_DEC_DEF = 3'd5;
  localparam logic [MW-1:0] M_IDX     = 3'd6;
  localparam logic [MW-1:0] M_IDX_DEF = 3'd7;
endpackage

// File: rtl/opnd_fsm.sv
module opnd_fsm
  import opnd_pkg::*;
#(
  parameter int RW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [MW-1:0] mode_i,
  input  logic [RW-1:0] reg_i,
  input  logic          mem_ack_i,
  output opnd_state_e   state_o,
  output logic [MW-1:0] mode_o,
  output logic [RW-1:0] reg_o
);
  opnd_state_e state_d;

  always_comb begin
    state_d = state_o;
    unique case (state_o)
      ST_IDLE: if (start_i) state_d = ST_DEC;
      ST_DEC: begin
        unique case (mode_o)
          M_REG:                  state_d = ST_DONE;
          M_DEF, M_INC, M_DEC:    state_d = ST_RD;
          M_INC_DEF, M_DEC_DEF:   state_d = ST_PTR;
          default:                state_d = ST_IDX;
        endcase
      end
      ST_IDX:  if (mem_ack_i) state_d = ST_ADD;
      ST_ADD:  state_d = (mode_o == M_IDX) ? ST_RD : ST_PTR;
      ST_PTR:  if (mem_ack_i) state_d = ST_RD;
      ST_RD:   if (mem_ack_i) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_IDLE;
      mode_o  <= '0;
      reg_o   <= '0;
    end else begin
      state_o <= state_d;
      if (state_o == ST_IDLE && start_i) begin
        mode_o <= mode_i;
        reg_o  <= reg_i;
      end
    end
  end

  // operand selection frozen for the whole sequence
  assert_sel_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != ST_IDLE && state_o != ST_DONE) |=> ($stable(mode_o) && $stable(reg_o)));
endmodule

// File: rtl/opnd_datapath.sv
module opnd_datapath
  import opnd_pkg::*;
#(
  parameter int DW     = 16,
  parameter int RW     = 3,
  parameter int PC_SEL = 7,
  parameter int STEP   = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  opnd_state_e   state_i,
  input  logic [MW-1:0] mode_i,
  input  logic [RW-1:0] reg_i,
  output logic [RW-1:0] rf_raddr_o,
  input  logic [DW-1:0] rf_rdata_i,
  output logic          rf_we_o,
  output logic [RW-1:0] rf_waddr_o,
  output logic [DW-1:0] rf_wdata_o,
  output logic          mem_req_o,
  output logic [DW-1:0] mem_addr_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] value_o,
  output logic [DW-1:0] ea_o,
  output logic          reg_direct_o
);
  localparam logic [DW-1:0] STEP_W = DW'(STEP);
  localparam logic [RW-1:0] PC_W   = RW'(PC_SEL);

  logic          idx_mode, pre_dec, writes_reg;
  logic [DW-1:0] ptr_q, ofs_q, stepped;

  assign idx_mode   = (mode_i == M_IDX) || (mode_i == M_IDX_DEF);
  assign pre_dec    = (mode_i == M_DEC) || (mode_i == M_DEC_DEF);
  assign writes_reg = (mode_i != M_REG) && (mode_i != M_DEF);
  assign stepped    = pre_dec ? (rf_rdata_i - STEP_W) : (rf_rdata_i + STEP_W);

  // decode reads the PC for indexed modes, everything else reads the selected register
  assign rf_raddr_o = (state_i == ST_DEC && idx_mode) ? PC_W : reg_i;
  assign rf_we_o    = (state_i == ST_DEC) && writes_reg;
  assign rf_waddr_o = idx_mode ? PC_W : reg_i;
  assign rf_wdata_o = stepped;

  assign mem_req_o  = (state_i == ST_IDX) || (state_i == ST_PTR) || (state_i == ST_RD);
  assign mem_addr_o = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q        <= '0;
      ofs_q        <= '0;
      value_o      <= '0;
      ea_o         <= '0;
      reg_direct_o <= 1'b0;
    end else begin
      unique case (state_i)
        ST_DEC: begin
          ptr_q <= pre_dec ? stepped : rf_rdata_i;
          if (mode_i == M_REG) begin
            value_o      <= rf_rdata_i;
            ea_o         <= {{(DW-RW){1'b0}}, reg_i};
            reg_direct_o <= 1'b1;
          end
        end
        ST_IDX: if (mem_ack_i) ofs_q <= mem_rdata_i;
        ST_ADD: ptr_q <= rf_rdata_i + ofs_q;
        ST_PTR: if (mem_ack_i) ptr_q <= mem_rdata_i;
        ST_RD: if (mem_ack_i) begin
          value_o      <= mem_rdata_i;
          ea_o         <= ptr_q;
          reg_direct_o <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // post-step and index modes address the pre-step value, pre-decrement addresses the written one (R4, R6, R7)
  assert_step_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && !pre_dec) |=> (mem_addr_o == $past(rf_wdata_o) - STEP_W));
  assert_step_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && pre_dec) |=> (mem_addr_o == $past(rf_wdata_o)));

  assert_single_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |=> !rf_we_o);
endmodule

// File: rtl/opnd_seq.sv
module opnd_seq
  import opnd_pkg::*;
#(
  parameter int DW     = 16,
  parameter int RW     = 3,
  parameter int PC_SEL = 7,
  parameter int STEP   = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    mode_i,
  input  logic [RW-1:0] reg_i,
  output logic          busy_o,
  output logic [RW-1:0] rf_raddr_o,
  input  logic [DW-1:0] rf_rdata_i,
  output logic          rf_we_o,
  output logic [RW-1:0] rf_waddr_o,
  output logic [DW-1:0] rf_wdata_o,
  output logic          mem_req_o,
  output logic [DW-1:0] mem_addr_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic [DW-1:0] value_o,
  output logic [DW-1:0] ea_o,
  output logic          reg_direct_o
);
  opnd_state_e   state;
  logic [MW-1:0] mode_q;
  logic [RW-1:0] reg_q;

  opnd_fsm #(.RW(RW)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .mode_i   (mode_i),
    .reg_i    (reg_i),
    .mem_ack_i(mem_ack_i),
    .state_o  (state),
    .mode_o   (mode_q),
    .reg_o    (reg_q)
  );

  opnd_datapath #(.DW(DW), .RW(RW), .PC_SEL(PC_SEL), .STEP(STEP)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .mode_i      (mode_q),
    .reg_i       (reg_q),
    .rf_raddr_o  (rf_raddr_o),
    .rf_rdata_i  (rf_rdata_i),
    .rf_we_o     (rf_we_o),
    .rf_waddr_o  (rf_waddr_o),
    .rf_wdata_o  (rf_wdata_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .value_o     (value_o),
    .ea_o        (ea_o),
    .reg_direct_o(reg_direct_o)
  );

  assign busy_o = (state != ST_IDLE);
  assign done_o = (state == ST_DONE);

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_direct_no_mem_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && reg_direct_o) |-> $past(!mem_req_o));
  assert_no_write_at_done_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rf_we_o);
endmodule

// File: tb/opnd_seq_tb.sv
module opnd_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        start = 1'b0;
  logic [2:0]  mode = '0, rsel = '0;
  logic        busy, rf_we, mem_req, done, rdir;
  logic [2:0]  rf_raddr, rf_waddr;
  logic [15:0] rf_rdata, rf_wdata, mem_addr, value, ea;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;

  logic [15:0] rf [8];
  logic [15:0] mem [256];
  int lat = 0, wcnt = 0;
  int reads_tot = 0, wr_tot = 0, done_tot = 0, cyc = 0;
  int checks = 0, errors = 0;
  logic [15:0] r_val, r_ea;
  logic r_dir;
  int r_reads, r_wr, r_lat;

  opnd_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .reg_i(rsel),
    .busy_o(busy), .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata), .rf_we_o(rf_we),
    .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .done_o(done), .value_o(value), .ea_o(ea), .reg_direct_o(rdir)
  );

  assign rf_rdata = rf[rf_raddr];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rf_we) begin
      rf[rf_waddr] <= rf_wdata;
      wr_tot <= wr_tot + 1;
    end
    if (done) done_tot <= done_tot + 1;
  end

  // memory responder: ack after lat idle cycles of a pending request
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      wcnt = 0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ack = 1'b1;
        mem_rdata = mem[mem_addr[8:1]];
        reads_tot = reads_tot + 1;
      end else wcnt = wcnt + 1;
    end
  end

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
    summary();
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    mem[a[8:1]] = d;
  endtask

  task automatic set_r(input int i, input logic [15:0] d);
    @(negedge clk);
    rf[i] <= d;
  endtask

  task automatic do_op(input logic [2:0] m, input logic [2:0] r);
    int rd0, wr0, n;
    @(negedge clk);
    rd0 = reads_tot; wr0 = wr_tot; n = 0;
    mode = m; rsel = r; start = 1'b1;
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      start = 1'b0;
      if (done || n > 200) break;
    end
    if (!done) chk("timeout", 16'(n), 16'd0);
    r_val = value; r_ea = ea; r_dir = rdir;
    r_reads = reads_tot - rd0; r_wr = wr_tot - wr0; r_lat = n;
  endtask

  task automatic t_reset();
    chk("R1 done", 16'(done), 16'd0);
    chk("R1 busy", 16'(busy), 16'd0);
    chk("R1 req", 16'(mem_req), 16'd0);
    chk("R1 we", 16'(rf_we), 16'd0);
  endtask

  task automatic t_mode0();
    set_r(3, 16'h1234);
    do_op(3'd0, 3'd3);
    chk("R2 value", r_val, 16'h1234);
    chk("R2 ea", r_ea, 16'h0003);
    chk("R2 direct", 16'(r_dir), 16'd1);
    chk("R2 reads", 16'(r_reads), 16'd0);
    chk("R2 writes", 16'(r_wr), 16'd0);
    chk("R2 latency", 16'(r_lat), 16'd2);
    chk("R2 reg", rf[3], 16'h1234);
  endtask

  task automatic t_mode1();
    set_r(2, 16'h0010); wr(16'h10, 16'hBEEF);
    do_op(3'd1, 3'd2);
    chk("R3 value", r_val, 16'hBEEF);
    chk("R3 ea", r_ea, 16'h0010);
    chk("R3 direct", 16'(r_dir), 16'd0);
    chk("R3 reads", 16'(r_reads), 16'd1);
    chk("R3 reg", rf[2], 16'h0010);
    chk("R11 writes m1", 16'(r_wr), 16'd0);
  endtask

  task automatic t_mode2();
    set_r(4, 16'h0020); wr(16'h20, 16'h1111);
    do_op(3'd2, 3'd4);
    chk("R4 value", r_val, 16'h1111);
    chk("R4 ea", r_ea, 16'h0020);
    chk("R4 reg", rf[4], 16'h0022);
    chk("R4 reads", 16'(r_reads), 16'd1);
  endtask

  task automatic t_mode3();
    set_r(1, 16'h0030); wr(16'h30, 16'h0040); wr(16'h40, 16'h2222);
    do_op(3'd3, 3'd1);
    chk("R5 value", r_val, 16'h2222);
    chk("R5 ea", r_ea, 16'h0040);
    chk("R5 reg", rf[1], 16'h0032);
    chk("R5 reads", 16'(r_reads), 16'd2);
  endtask

  task automatic t_mode45();
    set_r(5, 16'h0052); wr(16'h50, 16'h3333);
    do_op(3'd4, 3'd5);
    chk("R6 m4 value", r_val, 16'h3333);
    chk("R6 m4 ea", r_ea, 16'h0050);
    chk("R6 m4 reg", rf[5], 16'h0050);
    set_r(0, 16'h0062); wr(16'h60, 16'h0070); wr(16'h70, 16'h4444);
    do_op(3'd5, 3'd0);
    chk("R6 m5 value", r_val, 16'h4444);
    chk("R6 m5 ea", r_ea, 16'h0070);
    chk("R6 m5 reg", rf[0], 16'h0060);
    chk("R6 m5 reads", 16'(r_reads), 16'd2);
  endtask

  task automatic t_mode6();
    set_r(7, 16'h0080); set_r(2, 16'h0010);
    wr(16'h80, 16'h0090); wr(16'hA0, 16'h5555);
    do_op(3'd6, 3'd2);
    chk("R7 value", r_val, 16'h5555);
    chk("R7 ea", r_ea, 16'h00A0);
    chk("R7 pc", rf[7], 16'h0082);
    chk("R7 reg", rf[2], 16'h0010);
    chk("R7 reads", 16'(r_reads), 16'd2);
    chk("R11 writes m6", 16'(r_wr), 16'd1);
    // wrap of the index sum
    set_r(7, 16'h0084); set_r(3, 16'h00C0);
    wr(16'h84, 16'hFFF0); wr(16'hB0, 16'h6666);
    do_op(3'd6, 3'd3);
    chk("R7 wrap ea", r_ea, 16'h00B0);
    chk("R7 wrap value", r_val, 16'h6666);
    // PC-relative: offset added to the advanced PC
    set_r(7, 16'h0090);
    wr(16'h90, 16'h0010); wr(16'hA2, 16'h7777);
    do_op(3'd6, 3'd7);
    chk("R7 pcrel ea", r_ea, 16'h00A2);
    chk("R7 pcrel value", r_val, 16'h7777);
    chk("R7 pcrel pc", rf[7], 16'h0092);
  endtask

  task automatic t_mode7();
    set_r(7, 16'h00C0); set_r(4, 16'h0008);
    wr(16'hC0, 16'h00D0); wr(16'hD8, 16'h00E0); wr(16'hE0, 16'h8888);
    do_op(3'd7, 3'd4);
    chk("R8 value", r_val, 16'h8888);
    chk("R8 ea", r_ea, 16'h00E0);
    chk("R8 reads", 16'(r_reads), 16'd3);
    chk("R8 pc", rf[7], 16'h00C2);
  endtask

  task automatic t_twice();
    set_r(5, 16'h0100);
    wr(16'h100, 16'h0110); wr(16'h110, 16'hAAAA);
    wr(16'h102, 16'h0120); wr(16'h120, 16'hBBBB);
    do_op(3'd3, 3'd5);
    chk("R10 src value", r_val, 16'hAAAA);
    do_op(3'd3, 3'd5);
    chk("R10 dst ea", r_ea, 16'h0120);
    chk("R10 dst value", r_val, 16'hBBBB);
    chk("R10 reg twice", rf[5], 16'h0104);
  endtask

  task automatic t_slow_busy();
    int d0, n;
    lat = 3;
    set_r(6, 16'h0140); set_r(3, 16'h5A5A); wr(16'h140, 16'hC3C3);
    @(negedge clk);
    d0 = done_tot;
    mode = 3'd1; rsel = 3'd6; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk("R9 req held", 16'(mem_req), 16'd1);
    chk("R9 addr held", mem_addr, 16'h0140);
    mode = 3'd0; rsel = 3'd3; start = 1'b1;  // must be ignored
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!done && n < 50) begin @(negedge clk); n++; end
    chk("R9 value", value, 16'hC3C3);
    chk("R10 busy start ignored", 16'(rdir), 16'd0);
    repeat (6) @(negedge clk);
    chk("R10 one done", 16'(done_tot - d0), 16'd1);
    chk("R10 idle", 16'(busy), 16'd0);
    lat = 0;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) rf[i] = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_mode0();
    t_mode1();
    t_mode2();
    t_mode3();
    t_mode45();
    t_mode6();
    t_mode7();
    t_twice();
    t_slow_busy();
    summary();
  end
endmodule